// File: doc/BRIEF.md
# Odd-Increment Sequential Integer Square Root

This block returns the floor of the square root of an unsigned operand by walking the perfect squares from the bottom. A running square starts at 1 and an odd step starts at 3. While the running square does not exceed the operand, the step is added to the square and the step then grows by two. When the square first passes the operand, the root is half the step, less one. The time to finish depends on the operand and grows with its root: a root of r takes 2r+1 cycles of comparing and stepping.

A four-state Moore controller sequences the work. It idles and tracks the operand while waiting for a go strobe, then alternates compare and step cycles. It sits in a finished state, presenting the root, until go falls. A 2-bit state code is brought out so the sequence can be followed cycle by cycle. The step and square registers are one bit wider than the operand, so the last step cannot wrap.

Top module: `oddsum_isqrt`

## Requirements
- R1: While the asynchronous clear is high, the state code is 00 (idle), done is low and the result register holds 0.
- R2: In idle (code 00) the machine stays idle while go is low. On the rising edge where go is high, it moves to compare (code 01) and captures the operand present at that edge.
- R3: The state code is 00 for idle, 01 for compare, 10 for step and 11 for finished.
- R4: From compare the machine goes to step (10) when the running square is at most the captured operand, and to finished (11) otherwise. Step always returns to compare. For an operand whose floor root is r, the codes after leaving idle are 01, then r pairs of 10,01, then 11.
- R5: The result register is loaded on the clock edge that ends the first cycle in finished, so result_o shows the floor root from the second finished cycle onward.
- R6: done_o is high in exactly the cycles whose state code is 11.
- R7: Finished holds while go stays high and returns to idle on the first edge with go low. The result stays unchanged until the next load in finished, including the first finished cycle of the next run.
- R8: Changes on operand_i after the capturing edge do not affect the result of the run in progress.
- R9: An operand of 0 gives 0, an operand of 1 gives 1, and the largest operand gives its floor root with no overflow of the running square.
- R10: Each run restarts the square at 1 and the step at 3, so back-to-back runs each give the correct root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| arst_i | input | 1 | Asynchronous clear, active high |
| go_i | input | 1 | Start request; also holds the finished state |
| operand_i | input | WIDTH | Unsigned value whose root is wanted |
| result_o | output | (WIDTH+1)/2 | Registered floor square root |
| done_o | output | 1 | High while in the finished state |
| state_o | output | 2 | Controller state code |

## Verification
The controller assertions assume that go is a clean synchronous level: it is sampled only on rising edges and is free to stay high across a whole run. The overflow assertion assumes the captured operand fits WIDTH bits, which the port width enforces. The stimulus changes go and the operand only at falling edges. It lowers go only once finished has been seen for two cycles, and it deliberately scrambles the operand during a run so that the capture rule is tested.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_COMPARE = 2'b01,
        ST_STEP    = 2'b10,
        ST_FINISH  = 2'b11
    } isqrt_state_e;

endpackage

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
    import isqrt_pkg::*;
(
    input  logic       clk_i,
    input  logic       arst_i,
    input  logic       go_i,
    input  logic       le_i,
    output logic       cap_ld_o,
    output logic       sq_ld_o,
    output logic       step_ld_o,
    output logic       res_ld_o,
    output logic [1:0] state_o
);

    typedef struct packed {
        isqrt_state_e st;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE:    ctl_d.st = go_i ? ST_COMPARE : ST_IDLE;
            ST_COMPARE: ctl_d.st = le_i ? ST_STEP : ST_FINISH;
            ST_STEP:    ctl_d.st = ST_COMPARE;
            ST_FINISH:  ctl_d.st = go_i ? ST_FINISH : ST_IDLE;
            default:    ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) ctl_q <= '{st: ST_IDLE};
        else        ctl_q <= ctl_d;
    end

    // Moore decode of the load enables
    always_comb begin
        cap_ld_o  = (ctl_q.st == ST_IDLE);
        sq_ld_o   = (ctl_q.st == ST_STEP);
        step_ld_o = (ctl_q.st == ST_STEP);
        res_ld_o  = (ctl_q.st == ST_FINISH);
        state_o   = ctl_q.st;
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        (ctl_q.st == ST_IDLE && !go_i) |=> (ctl_q.st == ST_IDLE));

    // R4
    step_return_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        (ctl_q.st == ST_STEP) |=> (ctl_q.st == ST_COMPARE));

    // R4
    finish_entry_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        $rose(res_ld_o) |-> ($past(ctl_q.st) == ST_COMPARE && !$past(le_i)));

    // R7
    finish_hold_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        (ctl_q.st == ST_FINISH && go_i) |=> (ctl_q.st == ST_FINISH));

    // R3
    enable_excl_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        $onehot0({cap_ld_o, sq_ld_o, res_ld_o}));

endmodule

// File: rtl/isqrt_datapath.sv
module isqrt_datapath #(
    parameter int WIDTH = 32,
    parameter int RW    = (WIDTH + 1) / 2
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic [WIDTH-1:0] operand_i,
    input  logic             cap_ld_i,
    input  logic             sq_ld_i,
    input  logic             step_ld_i,
    input  logic             res_ld_i,
    output logic             le_o,
    output logic [RW-1:0]    result_o
);

    localparam int XW = WIDTH + 1;

    typedef struct packed {
        logic [WIDTH-1:0] opnd;
        logic [XW-1:0]    sq;
        logic [XW-1:0]    step;
        logic [RW-1:0]    res;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [XW-1:0] half_step;
    logic [XW-1:0] root_wide;

    always_comb begin
        half_step = dp_q.step >> 1;
        root_wide = half_step - XW'(1);
        dp_d      = dp_q;
        if (cap_ld_i) begin
            dp_d.opnd = operand_i;
            dp_d.sq   = XW'(1);
            dp_d.step = XW'(3);
        end
        if (sq_ld_i)   dp_d.sq   = dp_q.sq + dp_q.step;
        if (step_ld_i) dp_d.step = dp_q.step + XW'(2);
        if (res_ld_i)  dp_d.res  = root_wide[RW-1:0];
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            dp_q.opnd <= '0;
            dp_q.sq   <= XW'(1);
            dp_q.step <= XW'(3);
            dp_q.res  <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign le_o     = (dp_q.sq <= {1'b0, dp_q.opnd});
    assign result_o = dp_q.res;

    // R9
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        sq_ld_i |=> (dp_q.sq > $past(dp_q.sq)));

    // R8
    opnd_frozen_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        !cap_ld_i |=> $stable(dp_q.opnd));

    // R7
    result_hold_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        !res_ld_i |=> $stable(result_o));

endmodule

// File: rtl/oddsum_isqrt.sv
module oddsum_isqrt #(
    parameter  int WIDTH = 32,
    localparam int RW    = (WIDTH + 1) / 2
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic             go_i,
    input  logic [WIDTH-1:0] operand_i,
    output logic [RW-1:0]    result_o,
    output logic             done_o,
    output logic [1:0]       state_o
);

    logic le;
    logic cap_ld, sq_ld, step_ld, res_ld;
    logic [1:0] st_code;

    isqrt_ctrl u_ctrl (
        .clk_i     (clk_i),
        .arst_i    (arst_i),
        .go_i      (go_i),
        .le_i      (le),
        .cap_ld_o  (cap_ld),
        .sq_ld_o   (sq_ld),
        .step_ld_o (step_ld),
        .res_ld_o  (res_ld),
        .state_o   (st_code)
    );

    isqrt_datapath #(.WIDTH(WIDTH), .RW(RW)) u_dp (
        .clk_i     (clk_i),
        .arst_i    (arst_i),
        .operand_i (operand_i),
        .cap_ld_i  (cap_ld),
        .sq_ld_i   (sq_ld),
        .step_ld_i (step_ld),
        .res_ld_i  (res_ld),
        .le_o      (le),
        .result_o  (result_o)
    );

    assign state_o = st_code;
    assign done_o  = res_ld;

    // R6
    done_code_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        done_o == (state_o == 2'b11));

endmodule

// File: tb/oddsum_isqrt_bench.sv
module oddsum_isqrt_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int RW = (W + 1) / 2;

    logic          clk = 1'b0;
    logic          arst = 1'b1;
    logic          go = 1'b0;
    logic [W-1:0]  operand = '0;
    logic [RW-1:0] result;
    logic          done;
    logic [1:0]    state;

    int checks = 0;
    int failures = 0;
    int last_root = 0;

    oddsum_isqrt #(.WIDTH(W)) u_oddsum_isqrt (
        .clk_i     (clk),
        .arst_i    (arst),
        .go_i      (go),
        .operand_i (operand),
        .result_o  (result),
        .done_o    (done),
        .state_o   (state)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_root(input int a);
        int r = 0;
        while ((r + 1) * (r + 1) <= a) r++;
        return r;
    endfunction

    task automatic run(input int a, input bit scramble);
        int r = ref_root(a);
        int exp_q[$];
        exp_q.push_back(1);
        for (int i = 0; i < r; i++) begin
            exp_q.push_back(2);
            exp_q.push_back(1);
        end
        exp_q.push_back(3);
        @(negedge clk);
        chk(state == 2'b00, "R2 idle before go", int'(state), 0);
        operand = W'(a);
        go = 1'b1;
        for (int k = 0; k < exp_q.size(); k++) begin
            @(negedge clk);
            if (scramble && k == 0) operand = ~W'(a);
            chk(int'(state) == exp_q[k], "R4 state sequence", int'(state), exp_q[k]);
            chk(done == (exp_q[k] == 3), "R6 done flag", int'(done), int'(exp_q[k] == 3));
        end
        chk(int'(result) == last_root, "R7 result held in first finish cycle", int'(result), last_root);
        @(negedge clk);
        chk(state == 2'b11, "R7 finish holds with go high", int'(state), 3);
        chk(int'(result) == r, "R5 R9 R10 floor root", int'(result), r);
        if (scramble) chk(int'(result) == r, "R8 operand change ignored", int'(result), r);
        go = 1'b0;
        @(negedge clk);
        chk(state == 2'b00, "R7 return to idle", int'(state), 0);
        chk(done == 1'b0, "R6 done low in idle", int'(done), 0);
        chk(int'(result) == r, "R7 result held in idle", int'(result), r);
        last_root = r;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        chk(state == 2'b00, "R1 reset state", int'(state), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        chk(result == '0, "R1 reset result", int'(result), 0);
        @(negedge clk);
        arst = 1'b0;
        operand = W'(77);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(state == 2'b00, "R2 idle while go low", int'(state), 0);
        end
        run(0, 1'b0);
        run(1, 1'b0);
        run(2, 1'b0);
        run(3, 1'b1);
        run(4, 1'b0);
        run(8, 1'b0);
        run(9, 1'b1);
        run(15, 1'b0);
        run(16, 1'b0);
        run(99, 1'b1);
        run(100, 1'b0);
        run(1000, 1'b0);
        run(65024, 1'b0);
        run(65025, 1'b1);
        run(65535, 1'b0);
        run(0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule